// File: doc/BRIEF.md
# Multi-mode UART bit-clock generator

This block supplies the bit timing for a 16550-style serial port that has extra high-speed modes. It holds the divisor latch and three timing registers: a high-speed mode selector, a sample count and a sample point. A prescaler divides the input clock by the divisor to make a sample tick. A sample counter groups those ticks into bits and marks the bit boundary and the mid-bit sampling instant. The receive and transmit shifters use all three strobes.

The oversampling ratio depends on the mode. Modes 0 and 1 use 16 ticks per bit, with the mid-bit strobe on tick index 7. Mode 2 uses 4 ticks per bit, with the mid-bit strobe on index 1. Mode 3 uses a programmable count of up to 256 ticks per bit, and the mid-bit strobe falls on the index that the sample-point register holds. Software writes the registers through a word-offset register port; the byte address is the offset shifted left by two. The divisor-access bit of the line control register comes in as an input and gates writes to the divisor.

Top module: `uart_bitclk_gen`

## Requirements
- R1: While `rst_n` is low, all three strobes are low. After reset the divisor is 0, the mode is 0, the sample count is 0x00 and the sample point is 0xFF, so one bit lasts 16 clocks.
- R2: `sample_tick` pulses for one clock out of every D clocks, where D is the divisor. A divisor of 0 counts as 1.
- R3: In modes 0 and 1 a bit spans 16 sample ticks and `mid_strobe` coincides with tick index 7.
- R4: In mode 2 a bit spans 4 sample ticks and `mid_strobe` coincides with tick index 1.
- R5: In mode 3 a bit spans (sample_count + 1) sample ticks, from 1 up to 256.
- R6: In mode 3 `mid_strobe` fires on the tick whose in-bit index equals sample_point. It never fires when sample_point is greater than sample_count.
- R7: Offset 0 holds the divisor low byte and offset 1 the high byte. A write to either takes effect only while `dl_access` is 1. With `dl_access` at 0 the write is ignored and the timing is unchanged.
- R8: Offset 9 holds the mode in bits [1:0]. Offset 10 holds the sample count and offset 11 the sample point.
- R9: A write to offset 13 (rate fix) is accepted and has no effect. The block always runs purely from the divisor and mode settings, and the bit in progress keeps its length.
- R10: An accepted write to the divisor, the mode or the sample count restarts the timing. The first `bit_edge` then appears D × (ticks per bit) clocks after the write edge, counting the cycle right after that edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 4 | Word offset of the register written |
| wr_data | input | 8 | Write data |
| dl_access | input | 1 | Divisor-access bit from the line control register |
| sample_tick | output | 1 | One-clock pulse per oversampling tick |
| bit_edge | output | 1 | One-clock pulse on the last tick of each bit |
| mid_strobe | output | 1 | One-clock pulse on the mid-bit sampling tick |

## Verification
The checker assumes that the divisor, mode and sample count change only through the register port. That way each change lines up with a restart the checker can see, and its tick-gap and tick-index counters stay aligned with the design. The stimulus changes the configuration only through the port and holds every input steady for a full clock around the sampling edge. Sample-point values above the sample count are used on purpose to show that the mid-bit strobe stays silent.

// File: rtl/ubg_pkg.sv
// Shared constants for the UART bit-clock generator.
// Assumes registers are addressed by word offset (byte address = offset << 2).
package ubg_pkg;
    localparam logic [3:0] OFS_DIV_LO   = 4'd0;
    localparam logic [3:0] OFS_DIV_HI   = 4'd1;
    localparam logic [3:0] OFS_MODE     = 4'd9;
    localparam logic [3:0] OFS_SCOUNT   = 4'd10;
    localparam logic [3:0] OFS_SPOINT   = 4'd11;
    localparam logic [3:0] OFS_RATEFIX  = 4'd13;

    typedef enum logic [1:0] {
        MODE_X16     = 2'd0,
        MODE_X16_ALT = 2'd1,
        MODE_X4      = 2'd2,
        MODE_PROG    = 2'd3
    } hs_mode_e;
endpackage

// File: rtl/ubg_regs.sv
// Register bank: divisor latch (byte lanes, gated by dl_access), mode,
// sample count and sample point. Emits a restart pulse in the same cycle as
// any accepted write that alters bit timing. Rate-fix writes are ignored.
// Assumes DIV_W is a multiple of DATA_W.
module ubg_regs #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dl_access,
    output logic [DIV_W-1:0]  div_q,
    output logic [1:0]        mode_q,
    output logic [DATA_W-1:0] scount_q,
    output logic [DATA_W-1:0] spoint_q,
    output logic              restart
);
    import ubg_pkg::*;

    localparam int LANES = DIV_W / DATA_W;

    logic div_hit;

    // Divisor lanes, one register per byte, written only with dl_access set.
    for (genvar g = 0; g < LANES; g++) begin : g_div_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                div_q[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && dl_access && reg_sel == SEL_W'(g))
                div_q[g*DATA_W +: DATA_W] <= wr_data;
        end
    end

    // Mode, sample count and sample point registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_X16;
            scount_q <= '0;
            spoint_q <= '1;
        end else if (wr_en) begin
            if (reg_sel == OFS_MODE)   mode_q   <= wr_data[1:0];
            if (reg_sel == OFS_SCOUNT) scount_q <= wr_data;
            if (reg_sel == OFS_SPOINT) spoint_q <= wr_data;
        end
    end

    // Restart request for any write that changes tick or bit length.
    always_comb begin
        div_hit = dl_access && (reg_sel < SEL_W'(LANES));
        restart = wr_en && (div_hit || reg_sel == OFS_MODE || reg_sel == OFS_SCOUNT);
    end
endmodule

// File: rtl/ubg_prescaler.sv
// Divides the input clock by the divisor (0 treated as 1) into a one-cycle
// sample tick. Assumes restart arrives together with any divisor change.
module ubg_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_last;

    // Terminal count of the prescaler.
    always_comb begin
        eff_last = (div == '0) ? '0 : div - 1'b1;
        tick     = rst_n && (cnt == eff_last);
    end

    // Prescaler counter with synchronous clear on reset and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (tick)         cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ubg_sample_ctr.sv
// Counts sample ticks within a bit. Selects the bit length and mid-bit index
// from the mode. Assumes restart arrives with any mode or count change.
module ubg_sample_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] scount,
    input  logic [CNT_W-1:0] spoint,
    output logic             bit_edge,
    output logic             mid
);
    import ubg_pkg::*;

    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] mid_idx;

    // Per-mode bit length and sampling point.
    always_comb begin
        case (mode)
            MODE_X4: begin
                last_idx = CNT_W'(3);
                mid_idx  = CNT_W'(1);
            end
            MODE_PROG: begin
                last_idx = scount;
                mid_idx  = spoint;
            end
            default: begin
                last_idx = CNT_W'(15);
                mid_idx  = CNT_W'(7);
            end
        endcase
        bit_edge = tick && (idx == last_idx);
        mid      = tick && (idx == mid_idx);
    end

    // In-bit tick index, wrapping at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) idx <= '0;
        else if (bit_edge)     idx <= '0;
        else if (tick)         idx <= idx + 1'b1;
    end
endmodule

// File: rtl/uart_bitclk_gen.sv
// Top of the multi-mode UART bit-clock generator: register bank, clock
// prescaler and in-bit sample counter. Assumes a single clock domain and
// that dl_access is already synchronous to clk.
module uart_bitclk_gen #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dl_access,
    output logic              sample_tick,
    output logic              bit_edge,
    output logic              mid_strobe
);
    logic [DIV_W-1:0]  cfg_div;
    logic [1:0]        cfg_mode;
    logic [DATA_W-1:0] cfg_scount;
    logic [DATA_W-1:0] cfg_spoint;
    logic              cfg_restart;

    ubg_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .dl_access(dl_access), .div_q(cfg_div),
        .mode_q(cfg_mode), .scount_q(cfg_scount), .spoint_q(cfg_spoint),
        .restart(cfg_restart)
    );

    ubg_prescaler #(.DIV_W(DIV_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .restart(cfg_restart), .div(cfg_div),
        .tick(sample_tick)
    );

    ubg_sample_ctr #(.CNT_W(DATA_W)) i_sctr (
        .clk(clk), .rst_n(rst_n), .restart(cfg_restart), .tick(sample_tick),
        .mode(cfg_mode), .scount(cfg_scount), .spoint(cfg_spoint),
        .bit_edge(bit_edge), .mid(mid_strobe)
    );
endmodule

// File: rtl/ubg_checker.sv
// Property checker for uart_bitclk_gen, attached by bind. Keeps its own
// tick-gap and tick-index counters, cleared by the writes it sees at the ports.
module ubg_checker #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  reg_sel,
    input logic              dl_access,
    input logic              sample_tick,
    input logic              bit_edge,
    input logic              mid_strobe,
    input logic [DIV_W-1:0]  cfg_div,
    input logic [1:0]        cfg_mode,
    input logic [DATA_W-1:0] cfg_scount,
    input logic [DATA_W-1:0] cfg_spoint
);
    logic             rst_evt;
    logic [DIV_W:0]   gap;
    logic [DIV_W:0]   want_gap;
    logic [DATA_W:0]  tcnt;
    logic [DATA_W:0]  want_last;
    logic [DATA_W:0]  want_mid;

    // Independent view of the restart condition and expected indices.
    always_comb begin
        rst_evt   = wr_en && ((dl_access && reg_sel <= SEL_W'(1)) ||
                    reg_sel == SEL_W'(9) || reg_sel == SEL_W'(10));
        want_gap  = (cfg_div == '0) ? (DIV_W+1)'(1) : {1'b0, cfg_div};
        want_last = (cfg_mode == 2'd3) ? {1'b0, cfg_scount} :
                    (cfg_mode == 2'd2) ? (DATA_W+1)'(3) : (DATA_W+1)'(15);
        want_mid  = (cfg_mode == 2'd3) ? {1'b0, cfg_spoint} :
                    (cfg_mode == 2'd2) ? (DATA_W+1)'(1) : (DATA_W+1)'(7);
    end

    // Cycles since the last tick or restart, counting from 1.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt || sample_tick) gap <= (DIV_W+1)'(1);
        else                                  gap <= gap + 1'b1;
    end

    // Ticks seen in the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt) tcnt <= '0;
        else if (bit_edge)     tcnt <= '0;
        else if (sample_tick)  tcnt <= tcnt + 1'b1;
    end

    AST_STROBES_QUIET_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> !sample_tick && !bit_edge && !mid_strobe);                  // R1
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> gap == want_gap);                                      // R2
    AST_BIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        bit_edge |-> tcnt == want_last);                                       // R5
    AST_MID_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        mid_strobe |-> tcnt == want_mid);                                      // R6
    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !dl_access && reg_sel <= SEL_W'(1) |=> $stable(cfg_div));     // R7
    AST_RATEFIX_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_sel == SEL_W'(13) |=> $stable(cfg_div) && $stable(cfg_mode)
        && $stable(cfg_scount) && $stable(cfg_spoint));                        // R9
endmodule

bind uart_bitclk_gen ubg_checker #(.DIV_W(DIV_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .dl_access(dl_access), .sample_tick(sample_tick), .bit_edge(bit_edge),
    .mid_strobe(mid_strobe), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
    .cfg_scount(cfg_scount), .cfg_spoint(cfg_spoint)
);

// File: tb/test_uart_bitclk_gen.sv
// Self-checking bench: a vector table of configurations, each measured for
// bit period, ticks per bit and mid-strobe offset, then directed cases.
module test_uart_bitclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [7:0] wr_data = '0;
    logic       dl_access = 1'b0;
    logic       sample_tick, bit_edge, mid_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    uart_bitclk_gen i_uart_bitclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .dl_access(dl_access), .sample_tick(sample_tick),
        .bit_edge(bit_edge), .mid_strobe(mid_strobe)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] div;
        logic [7:0]  sc;
        logic [7:0]  sp;
        int          period;
        int          ticks;
        int          mid;
    } vec_t;

    // mid = cycles from one bit_edge to the mid strobe (0 = none)
    localparam vec_t VECS [8] = '{
        '{2'd0, 16'd3, 8'd0,   8'hFF, 48,  16,  24},
        '{2'd1, 16'd2, 8'd0,   8'hFF, 32,  16,  16},
        '{2'd2, 16'd5, 8'd0,   8'hFF, 20,  4,   10},
        '{2'd2, 16'd0, 8'd0,   8'hFF, 4,   4,   2},
        '{2'd3, 16'd1, 8'd15,  8'd7,  16,  16,  8},
        '{2'd3, 16'd2, 8'd255, 8'd127, 512, 256, 256},
        '{2'd3, 16'd3, 8'd4,   8'd1,  15,  5,   6},
        '{2'd3, 16'd1, 8'd15,  8'hFF, 16,  16,  0}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] d, input logic dl);
        wr_en = 1'b1; reg_sel = sel; wr_data = d; dl_access = dl;
        @(negedge clk);
        wr_en = 1'b0; dl_access = 1'b0;
    endtask

    task automatic configure(input vec_t v);
        wr(4'd0, v.div[7:0], 1'b1);
        wr(4'd1, v.div[15:8], 1'b1);
        wr(4'd10, v.sc, 1'b0);
        wr(4'd11, v.sp, 1'b0);
        wr(4'd9, {6'd0, v.mode}, 1'b0);
    endtask

    // Sync to a bit_edge, then measure one full bit.
    task automatic measure(output int per, output int tk, output int mo);
        int n = 0;
        per = 0; tk = 0; mo = 0;
        while (bit_edge !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        n = 0;
        do begin
            @(negedge clk); n++;
            if (sample_tick) tk++;
            if (mid_strobe && mo == 0) mo = n;
        end while (bit_edge !== 1'b1 && n < 5000);
        per = n;
    endtask

    function automatic string tag(input vec_t v);
        if (v.div == 16'd0) return "R2";
        if (v.mode == 2'd2) return "R4";
        if (v.mode == 2'd3) return "R5";
        return "R3";
    endfunction

    initial begin : watchdog
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        summary();
    end

    initial begin : main
        int per, tk, mo, n;
        // R1: strobes low during reset
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", int'({sample_tick, bit_edge, mid_strobe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        measure(per, tk, mo);
        chk("R1 default period", per, 16);
        chk("R1 default ticks", tk, 16);
        chk("R1 default mid", mo, 8);

        for (int i = 0; i < 8; i++) begin
            configure(VECS[i]);
            measure(per, tk, mo);
            chk({tag(VECS[i]), " period"}, per, VECS[i].period);
            chk({tag(VECS[i]), " ticks per bit"}, tk, VECS[i].ticks);
            chk((VECS[i].mode == 2'd3) ? "R6 mid offset" : "R3/mid offset", mo, VECS[i].mid);
        end

        // R7: divisor write without dl_access is ignored
        configure(VECS[0]);
        wr(4'd0, 8'd9, 1'b0);
        wr(4'd1, 8'd1, 1'b0);
        measure(per, tk, mo);
        chk("R7 locked divisor period", per, 48);

        // R8: mode field in bits [1:0] of offset 9
        wr(4'd9, 8'hFE, 1'b0);
        measure(per, tk, mo);
        chk("R8 mode 2 via bits 1:0", per, 12);
        wr(4'd9, 8'd0, 1'b0);

        // R9: rate-fix write leaves the running bit untouched
        measure(per, tk, mo);
        wr(4'd13, 8'd0, 1'b0);
        n = 1;
        while (bit_edge !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        chk("R9 rate-fix no restart", n, 48);

        // R10: mode write mid-bit restarts the timing
        repeat (20) @(negedge clk);
        wr(4'd9, 8'd0, 1'b0);
        n = 0;
        while (bit_edge !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        chk("R10 restart first edge", n, 47);

        // R10: divisor write restarts too (D=2 -> 31)
        repeat (5) @(negedge clk);
        wr(4'd0, 8'd2, 1'b1);
        n = 0;
        while (bit_edge !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        chk("R10 divisor restart", n, 31);

        // R1: reset restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        measure(per, tk, mo);
        chk("R1 period after re-reset", per, 16);

        summary();
    end
endmodule